// File: doc/BRIEF.md
# Interrupt-Level Banked Register File

This block is a register file made of sixteen complete register banks. Which bank software sees is set by the low four bits of a status word that the block holds. Bank 0 belongs to user code. Each interrupt level from 1 to 15 owns the bank with the same number. When an interrupt is taken, nothing has to be saved: the bank changes, and the new bank's top four registers get a descriptor of the event.

An external arbiter presents one request at a time. The request carries a level, a vector number and a device address, and the core supplies its current program counter. The block accepts the request in the same cycle if the level is above the bank in use. At the next clock edge it switches banks and deposits four values in the new bank: the vector, the device address, the old status word and the old program counter. A return strobe reloads the whole status word from register 14 of the current bank and hands register 15 back to the core as the resume address. Software can also write the status word directly.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word is 0 (bank 0 selected), every register of every bank reads 0, and both irq_ack and ret_valid are low.
- R2: The read and write ports address the register selected by rd_addr or wr_addr in the bank named by status bits [3:0]. A write leaves the same register number in every other bank unchanged.
- R3: irq_ack is high in the same cycle as irq_req only when irq_level is numerically greater than the current bank. A request at the same or a lower level is ignored and leaves the status word unchanged.
- R4: One cycle after an accepted request, status bits [3:0] equal the accepted level and status bits [31:4] keep their previous value.
- R5: One cycle after an accepted request, the new bank holds irq_vector in register 12, irq_dev in register 13, the previous status word in register 14 and cur_pc in register 15. Registers 0 to 11 of that bank are not touched.
- R6: One cycle after rti_req (with no accepted request), the status word equals register 14 of the bank that was current. In that same cycle ret_valid pulses high for one cycle, with ret_pc equal to register 15 of that bank.
- R7: A software write of the status word takes effect at the next clock edge. In the cycle of the write, the read port still addresses the old bank.
- R8: When several events meet in one cycle, an accepted interrupt wins over rti_req, and rti_req wins over a software status write. The losing events have no effect.
- R9: A register write in the same cycle as an interrupt entry lands in the bank that was current before the entry.
- R10: Interrupts nest. A higher level taken during service stacks its entry in its own bank, and successive returns restore the inner and then the outer context.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request from the external arbiter |
| irq_level | input | 4 | Level of the request (1 to 15) |
| irq_vector | input | 32 | Vector number stored on entry |
| irq_dev | input | 32 | Device address stored on entry |
| cur_pc | input | 32 | Program counter of the interrupted code |
| irq_ack | output | 1 | Request accepted this cycle |
| rti_req | input | 1 | Return-from-interrupt strobe |
| ret_valid | output | 1 | One-cycle pulse that qualifies ret_pc |
| ret_pc | output | 32 | Program counter to resume at |
| sr_we | input | 1 | Software write of the status word |
| sr_wdata | input | 32 | New status word |
| sr_rdata | output | 32 | Current status word |
| rd_addr | input | 4 | Read register number in the current bank |
| rd_data | output | 32 | Read data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Write register number in the current bank |
| wr_data | input | 32 | Write data |

## Verification
Some properties are checked on every clock by assertions. These cover the bank step on entry and the upward-only move that entry makes. They also cover the contents of the descriptor slots, the stability of the status word when no event is present, the result of a return, the result of a software status write, and the fact that a return pulse never follows an entry. Other behaviour can only be shown by the directed scenarios, because it needs knowledge of which bank a value was placed in many cycles earlier. This includes isolation between banks, a write that lands in the old bank during entry, the arbitration order when events collide, and the unwinding of nested levels back to user code.

// File: rtl/bankrf_pkg.sv
`timescale 1ns/1ps
package bankrf_pkg;
   // Status-word update source, in decreasing priority
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_IRQ  = 2'd1,
      EV_RTI  = 2'd2,
      EV_SRW  = 2'd3
   } sr_event_e;

   // Descriptor slots counted down from the top register of a bank
   localparam int CTX_SLOTS = 4;
endpackage

// File: rtl/bankrf_store.sv
`timescale 1ns/1ps
module bankrf_store #(
   parameter int DATA_W         = 32,
   parameter int BANK_W         = 4,
   parameter int REG_AW         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] cur_bank,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              sw_we,
   input  logic [REG_AW-1:0] sw_addr,
   input  logic [DATA_W-1:0] sw_data,
   input  logic              ctx_we,
   input  logic [BANK_W-1:0] ctx_bank,
   input  logic [DATA_W-1:0] ctx_vec,
   input  logic [DATA_W-1:0] ctx_dev,
   input  logic [DATA_W-1:0] ctx_sr,
   input  logic [DATA_W-1:0] ctx_pc,
   output logic [DATA_W-1:0] saved_sr,
   output logic [DATA_W-1:0] saved_pc
);
   import bankrf_pkg::*;

   localparam int NB       = 1 << BANK_W;
   localparam int NR       = 1 << REG_AW;
   localparam int SLOT_VEC = NR - CTX_SLOTS;
   localparam int SLOT_DEV = NR - CTX_SLOTS + 1;
   localparam int SLOT_SR  = NR - CTX_SLOTS + 2;
   localparam int SLOT_PC  = NR - CTX_SLOTS + 3;

   initial begin
      assert (NR >= CTX_SLOTS + 1)
         else $error("bankrf_store: a bank needs room for the descriptor slots");
   end

   logic [DATA_W-1:0] mem [NB][NR];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      for (genvar r = 0; r < NR; r++) begin : g_reg
         logic              ctx_hit;
         logic              sw_hit;
         logic [DATA_W-1:0] ctx_val;
         logic [DATA_W-1:0] q;

         if (r == SLOT_VEC) begin : g_vec
            assign ctx_val = ctx_vec;
         end else if (r == SLOT_DEV) begin : g_dev
            assign ctx_val = ctx_dev;
         end else if (r == SLOT_SR) begin : g_sr
            assign ctx_val = ctx_sr;
         end else if (r == SLOT_PC) begin : g_pc
            assign ctx_val = ctx_pc;
         end else begin : g_plain
            assign ctx_val = '0;
         end

         assign ctx_hit = ctx_we && (ctx_bank == BANK_W'(b)) && (r >= SLOT_VEC);
         assign sw_hit  = sw_we  && (cur_bank == BANK_W'(b)) && (sw_addr == REG_AW'(r));

         if (CLEAR_ON_RESET) begin : g_clr
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       q <= '0;
               else if (ctx_hit) q <= ctx_val;
               else if (sw_hit)  q <= sw_data;
            end
         end else begin : g_noclr
            always_ff @(posedge clk) begin
               if (ctx_hit)     q <= ctx_val;
               else if (sw_hit) q <= sw_data;
            end
         end

         assign mem[b][r] = q;
      end
   end

   assign rd_data  = mem[cur_bank][rd_addr];
   assign saved_sr = mem[cur_bank][SLOT_SR];
   assign saved_pc = mem[cur_bank][SLOT_PC];

   // R5: descriptor lands in the slots of the entered bank
   p_ctx_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_we |=> mem[$past(ctx_bank)][SLOT_VEC] == $past(ctx_vec));
   p_ctx_dev_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_we |=> mem[$past(ctx_bank)][SLOT_DEV] == $past(ctx_dev));
   p_ctx_sr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_we |=> mem[$past(ctx_bank)][SLOT_SR] == $past(ctx_sr));
   p_ctx_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_we |=> mem[$past(ctx_bank)][SLOT_PC] == $past(ctx_pc));
   // R2: a plain write reaches the addressed register of the current bank
   p_sw_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !ctx_we) |=> mem[$past(cur_bank)][$past(sw_addr)] == $past(sw_data));
endmodule

// File: rtl/bankrf_ctrl.sv
`timescale 1ns/1ps
module bankrf_ctrl #(
   parameter int DATA_W = 32,
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [BANK_W-1:0] irq_level,
   input  logic              rti_req,
   input  logic              sr_we,
   input  logic [DATA_W-1:0] sr_wdata,
   input  logic [DATA_W-1:0] saved_sr,
   input  logic [DATA_W-1:0] saved_pc,
   output logic [DATA_W-1:0] sr_q,
   output logic [BANK_W-1:0] cur_bank,
   output logic              irq_ack,
   output logic              ctx_we,
   output logic [BANK_W-1:0] ctx_bank,
   output logic              ret_valid,
   output logic [DATA_W-1:0] ret_pc
);
   import bankrf_pkg::*;

   initial begin
      assert (DATA_W > BANK_W)
         else $error("bankrf_ctrl: status word must be wider than the bank field");
   end

   sr_event_e ev;

   assign cur_bank = sr_q[BANK_W-1:0];
   assign irq_ack  = irq_req && (irq_level > cur_bank);
   assign ctx_we   = irq_ack;
   assign ctx_bank = irq_level;

   always_comb begin
      ev = EV_NONE;
      if (irq_ack)      ev = EV_IRQ;
      else if (rti_req) ev = EV_RTI;
      else if (sr_we)   ev = EV_SRW;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q      <= '0;
         ret_valid <= 1'b0;
         ret_pc    <= '0;
      end else begin
         ret_valid <= (ev == EV_RTI);
         case (ev)
            EV_IRQ:  sr_q <= {sr_q[DATA_W-1:BANK_W], irq_level};
            EV_RTI:  begin
               sr_q   <= saved_sr;
               ret_pc <= saved_pc;
            end
            EV_SRW:  sr_q <= sr_wdata;
            default: ;
         endcase
      end
   end

   // R4: entry selects the requested bank and keeps the upper status bits
   p_enter_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> (cur_bank == $past(irq_level))
                  && (sr_q[DATA_W-1:BANK_W] == $past(sr_q[DATA_W-1:BANK_W])));
   // R3: entry only ever moves to a higher bank
   p_enter_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> cur_bank > $past(cur_bank));
   // R3: with no event present the status word holds
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_ack && !rti_req && !sr_we) |=> $stable(sr_q));
   // R6: return reloads status and presents the resume address
   p_rti_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rti_req && !irq_ack) |=> ret_valid && (sr_q == $past(saved_sr))
                               && (ret_pc == $past(saved_pc)));
   // R7: software status write takes effect at the next edge
   p_srw_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_we && !irq_ack && !rti_req) |=> sr_q == $past(sr_wdata));
   // R8: an entry suppresses a colliding return
   p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !ret_valid);
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile #(
   parameter int DATA_W         = 32,
   parameter int BANK_W         = 4,
   parameter int REG_AW         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [BANK_W-1:0] irq_level,
   input  logic [DATA_W-1:0] irq_vector,
   input  logic [DATA_W-1:0] irq_dev,
   input  logic [DATA_W-1:0] cur_pc,
   output logic              irq_ack,
   input  logic              rti_req,
   output logic              ret_valid,
   output logic [DATA_W-1:0] ret_pc,
   input  logic              sr_we,
   input  logic [DATA_W-1:0] sr_wdata,
   output logic [DATA_W-1:0] sr_rdata,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   logic [BANK_W-1:0] cur_bank;
   logic              ctx_we;
   logic [BANK_W-1:0] ctx_bank;
   logic [DATA_W-1:0] saved_sr;
   logic [DATA_W-1:0] saved_pc;
   logic [DATA_W-1:0] sr_q;

   bankrf_ctrl #(.DATA_W(DATA_W), .BANK_W(BANK_W)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (irq_req),
      .irq_level (irq_level),
      .rti_req   (rti_req),
      .sr_we     (sr_we),
      .sr_wdata  (sr_wdata),
      .saved_sr  (saved_sr),
      .saved_pc  (saved_pc),
      .sr_q      (sr_q),
      .cur_bank  (cur_bank),
      .irq_ack   (irq_ack),
      .ctx_we    (ctx_we),
      .ctx_bank  (ctx_bank),
      .ret_valid (ret_valid),
      .ret_pc    (ret_pc)
   );

   bankrf_store #(
      .DATA_W(DATA_W), .BANK_W(BANK_W), .REG_AW(REG_AW),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_bank (cur_bank),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .sw_we    (wr_en),
      .sw_addr  (wr_addr),
      .sw_data  (wr_data),
      .ctx_we   (ctx_we),
      .ctx_bank (ctx_bank),
      .ctx_vec  (irq_vector),
      .ctx_dev  (irq_dev),
      .ctx_sr   (sr_q),
      .ctx_pc   (cur_pc),
      .saved_sr (saved_sr),
      .saved_pc (saved_pc)
   );

   assign sr_rdata = sr_q;
endmodule

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [3:0]  irq_level = '0;
   logic [31:0] irq_vector = '0;
   logic [31:0] irq_dev = '0;
   logic [31:0] cur_pc = '0;
   logic        irq_ack;
   logic        rti_req = 1'b0;
   logic        ret_valid;
   logic [31:0] ret_pc;
   logic        sr_we = 1'b0;
   logic [31:0] sr_wdata = '0;
   logic [31:0] sr_rdata;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   banked_regfile dut_i (
      .clk(clk), .rst_n(rst_n),
      .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector),
      .irq_dev(irq_dev), .cur_pc(cur_pc), .irq_ack(irq_ack),
      .rti_req(rti_req), .ret_valid(ret_valid), .ret_pc(ret_pc),
      .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // advance one edge, return 1 ns after it
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic clear_in();
      irq_req = 1'b0; rti_req = 1'b0; sr_we = 1'b0; wr_en = 1'b0;
   endtask

   task automatic peek(input logic [3:0] a, output logic [31:0] v);
      rd_addr = a;
      #0.5;
      v = rd_data;
   endtask

   task automatic poke(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic set_sr(input logic [31:0] d);
      sr_we = 1'b1; sr_wdata = d;
      step();
      sr_we = 1'b0;
   endtask

   task automatic raise(input logic [3:0] lvl, input logic [31:0] vec,
                        input logic [31:0] dev, input logic [31:0] pc);
      irq_req = 1'b1; irq_level = lvl; irq_vector = vec; irq_dev = dev; cur_pc = pc;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 status", sr_rdata, 32'h0);
      chk("R1 ret_valid", {31'b0, ret_valid}, 32'h0);
      chk("R1 irq_ack", {31'b0, irq_ack}, 32'h0);
      peek(4'd0, v);  chk("R1 reg0", v, 32'h0);
      peek(4'd15, v); chk("R1 reg15", v, 32'h0);
   endtask

   task automatic t_bank_rw();
      logic [31:0] v;
      poke(4'd3, 32'hA0A0_0003);
      peek(4'd3, v); chk("R2 bank0 write", v, 32'hA0A0_0003);
      set_sr(32'h1);
      peek(4'd3, v); chk("R2 bank1 isolated", v, 32'h0);
      poke(4'd3, 32'hB1B1_0003);
      set_sr(32'h0);
      peek(4'd3, v); chk("R2 bank0 kept", v, 32'hA0A0_0003);
   endtask

   task automatic t_srw();
      logic [31:0] v;
      sr_we = 1'b1; sr_wdata = 32'h2;
      peek(4'd3, v); chk("R7 old bank during write", v, 32'hA0A0_0003);
      step();
      sr_we = 1'b0;
      chk("R7 status after write", sr_rdata, 32'h2);
      peek(4'd3, v); chk("R7 new bank read", v, 32'h0);
      set_sr(32'h0000_AB00);
      chk("R7 status upper bits", sr_rdata, 32'h0000_AB00);
   endtask

   task automatic t_reject();
      raise(4'd0, 32'h1, 32'h2, 32'h3);
      #0.5;
      chk("R3 level0 no ack", {31'b0, irq_ack}, 32'h0);
      step();
      clear_in();
      chk("R3 level0 ignored", sr_rdata, 32'h0000_AB00);
   endtask

   task automatic t_entry();
      logic [31:0] v;
      raise(4'd5, 32'h25, 32'h77, 32'h1000);
      wr_en = 1'b1; wr_addr = 4'd7; wr_data = 32'h5555;
      #0.5;
      chk("R3 ack level5", {31'b0, irq_ack}, 32'h1);
      step();
      clear_in();
      chk("R4 bank5 entered", sr_rdata, 32'h0000_AB05);
      peek(4'd12, v); chk("R5 vector", v, 32'h25);
      peek(4'd13, v); chk("R5 device", v, 32'h77);
      peek(4'd14, v); chk("R5 old status", v, 32'h0000_AB00);
      peek(4'd15, v); chk("R5 old pc", v, 32'h1000);
      peek(4'd0, v);  chk("R5 low regs untouched", v, 32'h0);
      peek(4'd7, v);  chk("R9 write not in new bank", v, 32'h0);
      raise(4'd3, 32'h9, 32'h9, 32'h9);
      #0.5;
      chk("R3 lower level no ack", {31'b0, irq_ack}, 32'h0);
      step();
      clear_in();
      chk("R3 lower level ignored", sr_rdata, 32'h0000_AB05);
   endtask

   task automatic t_rti();
      logic [31:0] v;
      rti_req = 1'b1;
      step();
      rti_req = 1'b0;
      chk("R6 status restored", sr_rdata, 32'h0000_AB00);
      chk("R6 ret_valid", {31'b0, ret_valid}, 32'h1);
      chk("R6 ret_pc", ret_pc, 32'h1000);
      peek(4'd7, v); chk("R9 write in old bank", v, 32'h5555);
      step();
      chk("R6 ret_valid one cycle", {31'b0, ret_valid}, 32'h0);
   endtask

   task automatic t_nest();
      logic [31:0] v;
      raise(4'd3, 32'h33, 32'h34, 32'h2000);
      step(); clear_in();
      chk("R10 in level3", sr_rdata, 32'h0000_AB03);
      raise(4'd9, 32'h99, 32'h98, 32'h3000);
      step(); clear_in();
      chk("R10 in level9", sr_rdata, 32'h0000_AB09);
      peek(4'd14, v); chk("R10 level9 saved status", v, 32'h0000_AB03);
      rti_req = 1'b1; step(); rti_req = 1'b0;
      chk("R10 back to level3", sr_rdata, 32'h0000_AB03);
      chk("R10 inner ret_pc", ret_pc, 32'h3000);
      rti_req = 1'b1; step(); rti_req = 1'b0;
      chk("R10 back to user", sr_rdata, 32'h0000_AB00);
      chk("R10 outer ret_pc", ret_pc, 32'h2000);
      step();
   endtask

   task automatic t_prio();
      logic [31:0] v;
      raise(4'd4, 32'h44, 32'h45, 32'h4000);
      rti_req = 1'b1; sr_we = 1'b1; sr_wdata = 32'h7;
      step(); clear_in();
      chk("R8 irq beats rti and write", sr_rdata, 32'h0000_AB04);
      chk("R8 no return pulse", {31'b0, ret_valid}, 32'h0);
      peek(4'd15, v); chk("R8 entry pc", v, 32'h4000);
      rti_req = 1'b1; sr_we = 1'b1; sr_wdata = 32'h9;
      step(); clear_in();
      chk("R8 rti beats write", sr_rdata, 32'h0000_AB00);
      chk("R8 return pulse", {31'b0, ret_valid}, 32'h1);
      chk("R8 return pc", ret_pc, 32'h4000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      t_reset();
      t_bank_rw();
      t_srw();
      t_reject();
      t_entry();
      t_rti();
      t_nest();
      t_prio();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule